// File: doc/BRIEF.md
# Table-free bit-serial FIR filter (distributed arithmetic)

This block is an eight-tap finite impulse response filter that needs no multiplier and no table of precomputed coefficient sums. Each new sample enters a tap chain on a strobe. The block then scans the eight stored samples one bit position per clock, starting at the sign bit. In every cycle each tap's current bit either passes that tap's fixed unsigned coefficient or passes zero. The eight results go through carry-save compression, and one carry-propagate adder turns the last sum and carry vectors into a partial term.

A shift-left accumulator folds the partial terms together, most significant bit first. The sign-bit term is subtracted from the cleared accumulator in the first cycle. Every later term is added after the running value is doubled. After one cycle per sample bit, the accumulator holds the exact filter output and a one-cycle valid pulse marks it. The coefficients are fixed by a parameter. The sample width, the tap count and the coefficient width are also parameters.

Top module: `dafir_fir`

## Requirements
- R1: Asynchronous active-low reset clears the tap chain and the accumulator. While reset is held and in the first cycle after it, `res_vld` is 0 and `res_out` is 0.
- R2: A strobe shifts `smp_in` into the newest tap, and every older tap moves one place toward the oldest. Tap i is weighted by coefficient i, which is held in bits [8i+7:8i] of the `COEF` parameter. Feeding the value 1 followed by zeros therefore returns C0, C1, ... C7 in turn.
- R3: The result equals the sum over i of Ci·x(n−i). Samples are two's-complement signed and coefficients are unsigned. The result is exact in the two's-complement `res_out` of SW+CW+log2(TAPS) bits, even with all coefficients at 255 and all samples at the most negative value, at all ones, or at the largest positive value.
- R4: `res_vld` is high for exactly one cycle, SW clock edges after the edge that sampled the strobe, and it is never high at any other time.
- R5: A strobe while a computation is running abandons that computation: no valid pulse is produced for it, and the new sample's result follows SW edges later.
- R6: A strobe that coincides with the final accumulation cycle wins. The pending result is dropped, no valid pulse appears, and the accumulator is cleared.
- R7: A strobe in the cycle in which `res_vld` is high starts a new computation. The pulse that is showing still lasts exactly one cycle.
- R8: In the cycle after a strobe is sampled, `res_out` is 0 and `res_vld` is 0.
- R9: When no computation is running and no strobe arrives, `res_out` keeps its last value and no valid pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | Load strobe for a new sample; starts a computation |
| smp_in | input | SW (20) | New sample, two's complement |
| res_out | output | SW+CW+log2(TAPS) (31) | Accumulator, the filter output when `res_vld` is high |
| res_vld | output | 1 | One-cycle marker of a finished result |

## Verification
The restart strobe and the completion of a running result can land on the same clock edge. This happens when a strobe arrives on the last accumulation cycle, and again when a strobe arrives while the valid pulse is showing. The bench drives the strobe precisely on each of these edges. It then judges two things: that the abandoned result never raises valid, or that the visible pulse stays one cycle long, and that the accumulator is cleared. It also checks that the following result is the exact sum of products over the shifted history, computed by its own signed reference model. A second instance with all coefficients at their maximum receives the same extreme samples, so any accumulator overflow would show at the output.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    // Sequencer phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Width of one partial term: coefficient width plus growth of the tap sum
    function automatic int term_width(input int taps, input int cw);
        return cw + $clog2(taps);
    endfunction

endpackage

// File: rtl/dafir_seq.sv
// Bit-slice sequencer: walks the bit positions from the sign bit down to bit 0
module dafir_seq #(
    parameter int SW = 20,
    localparam int BW = $clog2(SW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          acc_en,
    output logic          acc_first,
    output logic          done,
    output logic [BW-1:0] bit_idx
);
    import dafir_pkg::*;

    localparam logic [BW-1:0] LAST = BW'(SW - 1);

    typedef struct packed {
        phase_e        ph;
        logic [BW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            // a strobe always restarts, even on the last slice
            s_d.ph  = PH_RUN;
            s_d.cnt = '0;
        end else if (s_q.ph == PH_RUN) begin
            if (s_q.cnt == LAST) begin
                s_d.ph   = PH_IDLE;
                s_d.cnt  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_en    = (s_q.ph == PH_RUN) && !start;
    assign acc_first = acc_en && (s_q.cnt == '0);
    assign bit_idx   = LAST - s_q.cnt;
    assign done      = s_q.done;

endmodule

// File: rtl/dafir_tapline.sv
// Sample delay line; exposes one bit position of every tap
module dafir_tapline #(
    parameter int TAPS = 8,
    parameter int SW   = 20,
    localparam int BW  = $clog2(SW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SW-1:0]   sample,
    input  logic [BW-1:0]   bit_idx,
    output logic [TAPS-1:0] slice
);

    typedef struct packed {
        logic [TAPS-1:0][SW-1:0] tap;
    } line_t;

    line_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.tap[0] = sample;
            for (int i = 1; i < TAPS; i++) begin
                t_d.tap[i] = t_q.tap[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_slice
        assign slice[i] = t_q.tap[i][bit_idx];
    end

endmodule

// File: rtl/dafir_csa_tree.sv
// Gates each coefficient by its tap bit, compresses 3:2 per level, resolves once
module dafir_csa_tree #(
    parameter int TAPS = 8,
    parameter int CW   = 8,
    parameter logic [TAPS*CW-1:0] COEF = '0,
    localparam int PW  = dafir_pkg::term_width(TAPS, CW)
) (
    input  logic [TAPS-1:0] slice,
    output logic [PW-1:0]   partial
);

    logic [PW-1:0] gated [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_gate
        assign gated[i] = slice[i] ? {{(PW-CW){1'b0}}, COEF[i*CW +: CW]} : '0;
    end

    logic [PW-1:0] sum_vec;
    logic [PW-1:0] car_vec;

    // Level-by-level reduction: every full group of three operands becomes a
    // sum and a shifted carry, and leftovers pass to the next level unchanged.
    // Truncating carries out of PW bits is exact, since the true total fits.
    always_comb begin
        logic [PW-1:0] cur [TAPS];
        logic [PW-1:0] nxt [TAPS];
        int            n;
        int            m;
        for (int k = 0; k < TAPS; k++) begin
            cur[k] = gated[k];
            nxt[k] = '0;
        end
        n = TAPS;
        m = 0;
        for (int lvl = 0; lvl < TAPS; lvl++) begin
            if (n > 2) begin
                for (int k = 0; k < TAPS; k++) begin
                    nxt[k] = '0;
                end
                m = 0;
                for (int g = 0; g < TAPS / 3; g++) begin
                    if (3 * g + 2 < n) begin
                        nxt[m]     = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
                        nxt[m + 1] = ((cur[3*g] & cur[3*g+1]) |
                                      (cur[3*g] & cur[3*g+2]) |
                                      (cur[3*g+1] & cur[3*g+2])) << 1;
                        m = m + 2;
                    end
                end
                for (int k = 0; k < TAPS; k++) begin
                    if ((k >= (n / 3) * 3) && (k < n)) begin
                        nxt[m] = cur[k];
                        m = m + 1;
                    end
                end
                for (int k = 0; k < TAPS; k++) begin
                    cur[k] = nxt[k];
                end
                n = m;
            end
        end
        sum_vec = cur[0];
        car_vec = (n > 1) ? cur[1] : '0;
    end

    // single carry-propagate stage
    assign partial = sum_vec + car_vec;

endmodule

// File: rtl/dafir_shiftacc.sv
// MSB-first accumulator: doubles, then subtracts the sign slice or adds the others
module dafir_shiftacc #(
    parameter int AW = 31,
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          first,
    input  logic [PW-1:0] partial,
    output logic [AW-1:0] acc
);

    typedef struct packed {
        logic [AW-1:0] val;
    } acc_t;

    acc_t a_d, a_q;
    logic [AW-1:0] term_ext;

    assign term_ext = {{(AW-PW){1'b0}}, partial};

    always_comb begin
        a_d = a_q;
        if (clr) begin
            a_d.val = '0;
        end else if (en) begin
            if (first) begin
                a_d.val = (a_q.val << 1) - term_ext;
            end else begin
                a_d.val = (a_q.val << 1) + term_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign acc = a_q.val;

endmodule

// File: rtl/dafir_fir.sv
module dafir_fir #(
    parameter int TAPS = 8,
    parameter int CW   = 8,
    parameter int SW   = 20,
    parameter logic [TAPS*CW-1:0] COEF = {8'd99, 8'd1, 8'd200, 8'd0,
                                          8'd17, 8'd128, 8'd255, 8'd3},
    localparam int PW  = dafir_pkg::term_width(TAPS, CW),
    localparam int AW  = SW + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  logic [SW-1:0] smp_in,
    output logic [AW-1:0] res_out,
    output logic          res_vld
);

    localparam int BW = $clog2(SW);

    logic          acc_en;
    logic          acc_first;
    logic [BW-1:0] bit_idx;
    logic [TAPS-1:0] slice;
    logic [PW-1:0] partial;

    dafir_seq #(.SW(SW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (smp_stb),
        .acc_en    (acc_en),
        .acc_first (acc_first),
        .done      (res_vld),
        .bit_idx   (bit_idx)
    );

    dafir_tapline #(.TAPS(TAPS), .SW(SW)) u_taps (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (smp_stb),
        .sample  (smp_in),
        .bit_idx (bit_idx),
        .slice   (slice)
    );

    dafir_csa_tree #(.TAPS(TAPS), .CW(CW), .COEF(COEF)) u_tree (
        .slice   (slice),
        .partial (partial)
    );

    dafir_shiftacc #(.AW(AW), .PW(PW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (smp_stb),
        .en      (acc_en),
        .first   (acc_first),
        .partial (partial),
        .acc     (res_out)
    );

endmodule

// File: rtl/dafir_fir_chk.sv
module dafir_fir_chk #(
    parameter int SW = 20,
    parameter int AW = 31
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_stb,
    input logic [AW-1:0] res_out,
    input logic          res_vld
);

    localparam int NW = $clog2(SW);

    // port-level timing model: when a valid pulse is due
    logic          run_q;
    logic [NW-1:0] n_q;
    logic          due_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            n_q   <= '0;
            due_q <= 1'b0;
        end else begin
            due_q <= 1'b0;
            if (smp_stb) begin
                run_q <= 1'b1;
                n_q   <= '0;
            end else if (run_q) begin
                if (n_q == NW'(SW - 1)) begin
                    run_q <= 1'b0;
                    n_q   <= '0;
                    due_q <= 1'b1;
                end else begin
                    n_q <= n_q + 1'b1;
                end
            end
        end
    end

    p_vld_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld == due_q);

    p_vld_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && smp_stb) |=> !res_vld);

    p_last_slice_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (n_q == NW'(SW - 1)) && smp_stb) |=> (res_out == '0));

    p_strobe_on_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && smp_stb) |=> (!res_vld && res_out == '0));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (res_out == '0 && !res_vld));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !smp_stb) |=> $stable(res_out));

endmodule

bind dafir_fir dafir_fir_chk #(.SW(SW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .res_out (res_out),
    .res_vld (res_vld)
);

// File: tb/tb_dafir_fir.sv
`timescale 1ns/1ps
module tb_dafir_fir;

    localparam int TAPS = 8;
    localparam int CW   = 8;
    localparam int SW   = 20;
    localparam int AW   = SW + CW + $clog2(TAPS);
    localparam logic [TAPS*CW-1:0] COEF_A = {8'd99, 8'd1, 8'd200, 8'd0,
                                             8'd17, 8'd128, 8'd255, 8'd3};
    localparam logic [TAPS*CW-1:0] COEF_M = {(TAPS*CW){1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic [SW-1:0] smp = '0;
    logic [AW-1:0] res_a, res_m;
    logic          vld_a, vld_m;

    dafir_fir #(.TAPS(TAPS), .CW(CW), .SW(SW), .COEF(COEF_A)) dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(stb), .smp_in(smp),
        .res_out(res_a), .res_vld(vld_a));

    dafir_fir #(.TAPS(TAPS), .CW(CW), .SW(SW), .COEF(COEF_M)) dut_max (
        .clk(clk), .rst_n(rst_n), .smp_stb(stb), .smp_in(smp),
        .res_out(res_m), .res_vld(vld_m));

    always #2.5 clk = ~clk;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     finished = 1'b0;
    longint hist [TAPS];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint coef_a(input int i);
        return longint'(COEF_A[i*CW +: CW]);
    endfunction

    function automatic longint model(input bit maxc);
        longint s = 0;
        for (int i = 0; i < TAPS; i++) begin
            s += (maxc ? 64'sd255 : coef_a(i)) * hist[i];
        end
        return s;
    endfunction

    function automatic longint sv(input logic [AW-1:0] r);
        return longint'($signed(r));
    endfunction

    // called just after a negedge; returns at the next negedge with the strobe low
    task automatic push(input longint s, input string req);
        for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        stb = 1'b1;
        smp = s[SW-1:0];
        @(negedge clk);
        stb = 1'b0;
        chk(res_a == '0 && !vld_a && !vld_m, req, sv(res_a), 0);
    endtask

    // from the negedge after the strobe edge to the negedge showing valid
    task automatic wait_done(input string req);
        bit early = 1'b0;
        for (int m = 2; m <= SW; m++) begin
            @(negedge clk);
            if (vld_a || vld_m) early = 1'b1;
        end
        chk(!early, "R4 no early valid", early, 0);
        @(negedge clk);
        chk(vld_a && vld_m, "R4 valid after SW edges", vld_a, 1);
        chk(sv(res_a) == model(1'b0), req, sv(res_a), model(1'b0));
        chk(sv(res_m) == model(1'b1), req, sv(res_m), model(1'b1));
    endtask

    task automatic one_cycle_pulse();
        @(negedge clk);
        chk(!vld_a && !vld_m, "R4 pulse one cycle", vld_a, 0);
    endtask

    task automatic t_reset();
        chk(res_a == '0 && !vld_a && res_m == '0 && !vld_m, "R1 reset state", sv(res_a), 0);
    endtask

    task automatic t_impulse();
        push(1, "R8 clear after strobe");
        wait_done("R2 impulse tap 0");
        chk(sv(res_a) == coef_a(0), "R2 C0 weight", sv(res_a), coef_a(0));
        one_cycle_pulse();
        for (int k = 1; k < TAPS; k++) begin
            push(0, "R8 clear after strobe");
            wait_done("R2 impulse shift");
            chk(sv(res_a) == coef_a(k), "R2 tap order", sv(res_a), coef_a(k));
        end
        one_cycle_pulse();
    endtask

    task automatic t_patterns();
        longint vals [10] = '{12345, -777, 524287, -524288, 3, -1, 70000, -99999, 0, 255};
        foreach (vals[i]) begin
            push(vals[i], "R8 clear after strobe");
            wait_done("R3 mixed pattern");
        end
        one_cycle_pulse();
    endtask

    task automatic t_extremes();
        for (int k = 0; k < TAPS; k++) begin
            push(-1, "R8 clear after strobe");
            wait_done("R3 all-ones samples");
        end
        for (int k = 0; k < TAPS; k++) begin
            push(-524288, "R8 clear after strobe");
            wait_done("R3 most negative samples");
        end
        for (int k = 0; k < TAPS; k++) begin
            push(524287, "R8 clear after strobe");
            wait_done("R3 largest positive samples");
        end
        one_cycle_pulse();
    endtask

    task automatic t_idle();
        logic [AW-1:0] held = res_a;
        bit bad = 1'b0;
        for (int m = 0; m < 12; m++) begin
            @(negedge clk);
            if (res_a != held || vld_a || vld_m) bad = 1'b1;
        end
        chk(!bad, "R9 idle hold", sv(res_a), sv(held));
    endtask

    task automatic t_restart();
        bit seen = 1'b0;
        push(4321, "R8 clear after strobe");
        for (int m = 0; m < 6; m++) begin
            @(negedge clk);
            if (vld_a) seen = 1'b1;
        end
        push(-2468, "R5 restart clears");
        wait_done("R5 restart result");
        chk(!seen, "R5 abandoned run silent", seen, 0);
        one_cycle_pulse();
    endtask

    task automatic t_last_cycle();
        bit seen = 1'b0;
        push(-31000, "R8 clear after strobe");
        for (int m = 2; m <= SW; m++) begin
            @(negedge clk);
            if (vld_a) seen = 1'b1;
        end
        push(17, "R6 strobe on last slice drops result");
        chk(!seen, "R6 no early valid", seen, 0);
        wait_done("R6 new result");
        one_cycle_pulse();
    endtask

    task automatic t_back2back();
        push(600, "R8 clear after strobe");
        wait_done("R7 first result");
        push(-600, "R7 strobe on valid cycle");
        wait_done("R7 second result");
        one_cycle_pulse();
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < TAPS; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_impulse();
        t_patterns();
        t_extremes();
        t_idle();
        t_restart();
        t_last_cycle();
        t_back2back();
        t_idle();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule